// File: doc/BRIEF.md
# Event Counter Box with Freeze and Overflow Status

This block counts hardware events for performance analysis. It holds one fixed counter and four general counters, and all of them are 48 bits wide. The fixed counter adds one in every cycle in which its single event input is high. Each general counter has a control register. That register picks one source lane from a shared event bus and masks the sub-event bits of that lane. The sum of the unmasked bits is the event count for the cycle. The control register can also shape the count: it can count only rising activity, or count only the cycles in which the count reaches a threshold.

Software reaches every register through a 32-bit word port with an address, a write strobe and a combinational read-data output. A box-control register holds a freeze bit for all counters. It also has two write-only pulse bits: one clears every counter and one clears every control register. A status register collects the overflow flags of all five counters, and software clears each flag by writing one to it.

Register map (word addresses):
- 0: box control.
- 1: overflow status.
- 2 and 3: fixed counter, low half then high half.
- 4 to 11: general counters 1 to 4, as low/high pairs (counter k at 2+2k and 3+2k).
- 12 to 15: control registers of general counters 1 to 4.

Top module: `pmon_box`

## Requirements
- R1: After reset, every register reads 0 at all 16 addresses.
- R2: The event count of a general counter is the number of ones in (source lane `sel` of `ev_i` AND the unit mask). Lane s occupies bits [4s+3:4s] of `ev_i`. Control fields: `sel` in bits [2:0] and the unit mask in bits [11:8]. With edge mode and threshold both 0, the counter adds the event count every cycle. The fixed counter adds 1 in each cycle in which `fixed_ev_i` is 1.
- R3: With the threshold (control bits [27:24]) nonzero and edge mode off, a general counter adds 1 in each cycle in which the event count is at least the threshold. In every other cycle it adds 0.
- R4: With edge mode on (control bit 18), a general counter adds 1 only in a cycle whose event count is nonzero while the previous cycle's count was zero. Edge mode takes precedence over the threshold.
- R5: While box-control bit 8 is 1, every counter holds its value and ignores events. Register writes to the counters still take effect. Bit 8 reads back as written.
- R6: Writing box control with bit 1 set clears all five counters in that cycle. The control registers keep their values.
- R7: Writing box control with bit 0 set clears all four control registers in that cycle. Bits 1 and 0 of box control always read 0.
- R8: Writing a control register with bit 17 set clears that register's counter only, while the other fields load as written. Bit 17 reads back as 0.
- R9: A counter wraps from all ones to zero. On a wrap, status bit j is set, where bit 0 belongs to the fixed counter and bit k to general counter k. A general counter's bit is set only if its overflow-enable bit (control bit 20) was 1. The fixed counter always sets its bit.
- R10: Writing 1 to a status bit in bits [4:0] clears it, and writing 0 leaves it unchanged. If a wrap occurs in the same cycle as the clear, the bit stays set.
- R11: Writing address 2+2j loads bits [31:0] of counter j, and writing 3+2j loads bits [47:32] from write data [15:0]. A counter write overrides any event increment in that cycle.
- R12: Box-control bits 17:16 read back as written and have no effect. All other box-control bits except bit 8 read 0. Status bits 31:5 read 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_i | input | 32 | Event bus: 8 source lanes of 4 sub-event bits each |
| fixed_ev_i | input | 1 | Increment request for the fixed counter |
| reg_addr_i | input | 4 | Register word address |
| reg_wr_i | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |

## Verification
The assertions check the following on every cycle:
- a frozen box without a write leaves all counters unchanged;
- a counter-clear pulse zeroes all five counters on the next cycle;
- a low-half write lands over any coincident increment;
- the fixed counter's status flag rises only out of an all-ones value;
- a write-one clear drops the flag unless a wrap coincides;
- the write-only and ignored bits read as zero.

Only the bench's scenarios show the rest, because it needs a sequence of inputs: the popcount under a partial unit mask, threshold and edge shaping across several event patterns, overflow-enable gating on a general counter, and the per-counter and control-register clears. The random phase also puts random control values, near-overflow counter preloads and freeze toggling against a cycle model of the block.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  typedef enum logic [2:0] {K_NONE, K_BOX, K_STAT, K_CLO, K_CHI, K_CTL} reg_kind_e;

  localparam int unsigned A_BOX      = 0;
  localparam int unsigned A_STAT     = 1;
  localparam int unsigned A_CTR_BASE = 2;

  // box control bits
  localparam int unsigned B_RST_CTL = 0;
  localparam int unsigned B_RST_CTR = 1;
  localparam int unsigned B_FRZ     = 8;
  localparam int unsigned B_RSV_LSB = 16;

  // counter control bits
  localparam int unsigned C_SEL_LSB   = 0;
  localparam int unsigned C_UMASK_LSB = 8;
  localparam int unsigned C_RST       = 17;
  localparam int unsigned C_EDGE      = 18;
  localparam int unsigned C_OVEN      = 20;
  localparam int unsigned C_THR_LSB   = 24;
endpackage

// File: rtl/pmon_regdec.sv
module pmon_regdec
  import pmon_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NCTR     = 5,
  parameter int unsigned NUM_GEN  = 4,
  parameter int unsigned CTL_BASE = 12,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned CIDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CIDX_W-1:0] cidx_o
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] coff;

  always_comb begin
    off    = addr_i - ADDR_W'(A_CTR_BASE);
    coff   = addr_i - ADDR_W'(CTL_BASE);
    idx_o  = off[IDX_W:1];
    cidx_o = coff[CIDX_W-1:0];
    kind_o = K_NONE;
    if (addr_i == ADDR_W'(A_BOX))             kind_o = K_BOX;
    else if (addr_i == ADDR_W'(A_STAT))       kind_o = K_STAT;
    else if (int'(addr_i) < int'(CTL_BASE))   kind_o = off[0] ? K_CHI : K_CLO;
    else if (int'(addr_i) < int'(CTL_BASE + NUM_GEN)) kind_o = K_CTL;
  end
endmodule

// File: rtl/pmon_evt_shaper.sv
module pmon_evt_shaper #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned THR_W   = 4,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned INC_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC*NUM_SUB-1:0] ev_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [NUM_SUB-1:0]         umask_i,
  input  logic                       edge_i,
  input  logic [THR_W-1:0]           thr_i,
  output logic [INC_W-1:0]           inc_o
);
  logic [NUM_SUB-1:0] sub;
  logic [INC_W-1:0]   cnt;
  logic               prev_nz_q;

  always_comb begin
    sub = ev_i[int'(sel_i)*NUM_SUB +: NUM_SUB];
    cnt = '0;
    for (int b = 0; b < NUM_SUB; b++) cnt = cnt + INC_W'(sub[b] & umask_i[b]);
    if (edge_i)
      inc_o = (cnt != '0 && !prev_nz_q) ? INC_W'(1) : '0;
    else if (thr_i != '0)
      inc_o = (32'(cnt) >= 32'(thr_i)) ? INC_W'(1) : '0;
    else
      inc_o = cnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_nz_q <= 1'b0;
    else         prev_nz_q <= (cnt != '0);
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int unsigned CTR_W = 48,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  input  logic             frz_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int unsigned HI_W = CTR_W - 32;

  logic [CTR_W:0] sum;
  logic           hold;

  assign sum    = {1'b0, cnt_o} + (CTR_W+1)'(inc_i);
  assign hold   = clr_i | wr_lo_i | wr_hi_i | frz_i;
  assign wrap_o = ~hold & sum[CTR_W];

  // priority: clear, write, freeze, count
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (wr_lo_i) cnt_o[31:0] <= wdata_i;
    else if (wr_hi_i) cnt_o[CTR_W-1:32] <= wdata_i[HI_W-1:0];
    else if (!frz_i)  cnt_o <= sum[CTR_W-1:0];
endmodule

// File: rtl/pmon_box.sv
module pmon_box
  import pmon_pkg::*;
#(
  parameter int unsigned NUM_GEN = 4,
  parameter int unsigned CTR_W   = 48,
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned THR_W   = 4,
  localparam int unsigned NCTR     = NUM_GEN + 1,
  localparam int unsigned CTL_BASE = A_CTR_BASE + 2*NCTR,
  localparam int unsigned ADDR_W   = $clog2(CTL_BASE + NUM_GEN),
  localparam int unsigned EV_W     = NUM_SRC * NUM_SUB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EV_W-1:0]   ev_i,
  input  logic              fixed_ev_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  localparam int unsigned SEL_W  = $clog2(NUM_SRC);
  localparam int unsigned INC_W  = $clog2(NUM_SUB + 1);
  localparam int unsigned IDX_W  = $clog2(NCTR);
  localparam int unsigned CIDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
  localparam int unsigned HI_W   = CTR_W - 32;

  reg_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [CIDX_W-1:0] cidx;

  logic              frz_q;
  logic [1:0]        rsv_q;
  logic [NCTR-1:0]   stat_q;
  logic [NCTR-1:0]   wrap;
  logic [NCTR-1:0]   ovf_set;
  logic [NCTR-1:0]   stat_clr;

  logic [CTR_W-1:0]  cnt_q [NCTR];
  logic [NCTR*CTR_W-1:0] cnt_all;

  logic [SEL_W-1:0]   sel_q   [NUM_GEN];
  logic [NUM_SUB-1:0] umask_q [NUM_GEN];
  logic [THR_W-1:0]   thr_q   [NUM_GEN];
  logic [NUM_GEN-1:0] edge_q;
  logic [NUM_GEN-1:0] oven_q;

  logic box_we, stat_we, rst_ctr, rst_ctl;

  pmon_regdec #(
    .ADDR_W  (ADDR_W),
    .NCTR    (NCTR),
    .NUM_GEN (NUM_GEN),
    .CTL_BASE(CTL_BASE),
    .IDX_W   (IDX_W),
    .CIDX_W  (CIDX_W)
  ) u_dec (
    .addr_i(reg_addr_i),
    .kind_o(kind),
    .idx_o (idx),
    .cidx_o(cidx)
  );

  assign box_we   = reg_wr_i && (kind == K_BOX);
  assign stat_we  = reg_wr_i && (kind == K_STAT);
  assign rst_ctr  = box_we && reg_wdata_i[B_RST_CTR];
  assign rst_ctl  = box_we && reg_wdata_i[B_RST_CTL];
  assign stat_clr = stat_we ? reg_wdata_i[NCTR-1:0] : '0;

  // box control
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      frz_q <= 1'b0;
      rsv_q <= '0;
    end else if (box_we) begin
      frz_q <= reg_wdata_i[B_FRZ];
      rsv_q <= reg_wdata_i[B_RSV_LSB +: 2];
    end

  // overflow status: hardware set wins over write-one clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | ovf_set;

  // fixed counter
  pmon_counter #(
    .CTR_W(CTR_W),
    .INC_W(INC_W)
  ) u_fix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_ctr),
    .wr_lo_i(reg_wr_i && kind == K_CLO && idx == '0),
    .wr_hi_i(reg_wr_i && kind == K_CHI && idx == '0),
    .wdata_i(reg_wdata_i),
    .frz_i  (frz_q),
    .inc_i  (INC_W'(fixed_ev_i)),
    .cnt_o  (cnt_q[0]),
    .wrap_o (wrap[0])
  );
  assign ovf_set[0] = wrap[0];

  for (genvar k = 0; k < NUM_GEN; k++) begin : g_gen
    logic             ctl_we;
    logic             clr;
    logic [INC_W-1:0] inc;

    assign ctl_we = reg_wr_i && (kind == K_CTL) && (cidx == CIDX_W'(k));
    assign clr    = rst_ctr || (ctl_we && reg_wdata_i[C_RST]);

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        sel_q[k]   <= '0;
        umask_q[k] <= '0;
        thr_q[k]   <= '0;
        edge_q[k]  <= 1'b0;
        oven_q[k]  <= 1'b0;
      end else if (rst_ctl) begin
        sel_q[k]   <= '0;
        umask_q[k] <= '0;
        thr_q[k]   <= '0;
        edge_q[k]  <= 1'b0;
        oven_q[k]  <= 1'b0;
      end else if (ctl_we) begin
        sel_q[k]   <= reg_wdata_i[C_SEL_LSB +: SEL_W];
        umask_q[k] <= reg_wdata_i[C_UMASK_LSB +: NUM_SUB];
        thr_q[k]   <= reg_wdata_i[C_THR_LSB +: THR_W];
        edge_q[k]  <= reg_wdata_i[C_EDGE];
        oven_q[k]  <= reg_wdata_i[C_OVEN];
      end

    pmon_evt_shaper #(
      .NUM_SRC(NUM_SRC),
      .NUM_SUB(NUM_SUB),
      .THR_W  (THR_W),
      .SEL_W  (SEL_W),
      .INC_W  (INC_W)
    ) u_shp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev_i),
      .sel_i  (sel_q[k]),
      .umask_i(umask_q[k]),
      .edge_i (edge_q[k]),
      .thr_i  (thr_q[k]),
      .inc_o  (inc)
    );

    pmon_counter #(
      .CTR_W(CTR_W),
      .INC_W(INC_W)
    ) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .wr_lo_i(reg_wr_i && kind == K_CLO && idx == IDX_W'(k+1)),
      .wr_hi_i(reg_wr_i && kind == K_CHI && idx == IDX_W'(k+1)),
      .wdata_i(reg_wdata_i),
      .frz_i  (frz_q),
      .inc_i  (inc),
      .cnt_o  (cnt_q[k+1]),
      .wrap_o (wrap[k+1])
    );
    assign ovf_set[k+1] = wrap[k+1] & oven_q[k];
  end

  for (genvar j = 0; j < NCTR; j++) begin : g_flat
    assign cnt_all[j*CTR_W +: CTR_W] = cnt_q[j];
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (kind)
      K_BOX: begin
        reg_rdata_o[B_FRZ]          = frz_q;
        reg_rdata_o[B_RSV_LSB +: 2] = rsv_q;
      end
      K_STAT: reg_rdata_o[NCTR-1:0] = stat_q;
      K_CLO:  reg_rdata_o = cnt_q[idx][31:0];
      K_CHI:  reg_rdata_o[HI_W-1:0] = cnt_q[idx][CTR_W-1:32];
      K_CTL: begin
        reg_rdata_o[C_SEL_LSB +: SEL_W]     = sel_q[cidx];
        reg_rdata_o[C_UMASK_LSB +: NUM_SUB] = umask_q[cidx];
        reg_rdata_o[C_THR_LSB +: THR_W]     = thr_q[cidx];
        reg_rdata_o[C_EDGE]                 = edge_q[cidx];
        reg_rdata_o[C_OVEN]                 = oven_q[cidx];
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pmon_box_chk.sv
module pmon_box_chk #(
  parameter int unsigned NCTR   = 5,
  parameter int unsigned CTR_W  = 48,
  parameter int unsigned ADDR_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic                  reg_wr_i,
  input logic [31:0]           reg_wdata_i,
  input logic [31:0]           reg_rdata_o,
  input logic                  frz_q,
  input logic [NCTR-1:0]       stat_q,
  input logic [NCTR-1:0]       wrap,
  input logic [NCTR*CTR_W-1:0] cnt_all
);
  p_freeze_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !reg_wr_i) |=> $stable(cnt_all));

  p_ctrs_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(0) && reg_wdata_i[1]) |=> (cnt_all == '0));

  p_wr_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(2)) |=> (cnt_all[31:0] == $past(reg_wdata_i)));

  p_fix_ovf_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[0]) |-> ($past(cnt_all[CTR_W-1:0]) == {CTR_W{1'b1}}));

  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[0] && !wrap[0]) |=> !stat_q[0]);

  p_box_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(0)) |-> (reg_rdata_o[1:0] == 2'b00 && reg_rdata_o[15:9] == '0));

  p_stat_hi_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(1)) |-> (reg_rdata_o[31:NCTR] == '0));
endmodule

bind pmon_box pmon_box_chk #(
  .NCTR  (NCTR),
  .CTR_W (CTR_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .frz_q      (frz_q),
  .stat_q     (stat_q),
  .wrap       (wrap),
  .cnt_all    (cnt_all)
);

// File: tb/pmon_box_tb.sv
module pmon_box_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ev_i = '0;
  logic        fixed_ev_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pmon_box u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ev_i       (ev_i),
    .fixed_ev_i (fixed_ev_i),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o)
  );

  // reference model, index 0 = fixed, 1..4 = general
  logic [47:0] m_cnt  [5];
  logic [4:0]  m_stat;
  logic        m_frz;
  logic [1:0]  m_rsv;
  logic [2:0]  m_sel  [5];
  logic [3:0]  m_um   [5];
  logic [3:0]  m_thr  [5];
  logic        m_edge [5];
  logic        m_oven [5];
  logic        m_pnz  [5];

  function automatic logic [31:0] mkev(input int src, input logic [3:0] bits);
    return 32'(bits) << (src*4);
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [31:0] r;
    int j;
    r = '0;
    if (a == 0) begin
      r[8] = m_frz; r[17:16] = m_rsv;
    end else if (a == 1) begin
      r[4:0] = m_stat;
    end else if (a < 12) begin
      j = (int'(a) - 2) / 2;
      if (a[0] == 1'b0) r = m_cnt[j][31:0];
      else              r[15:0] = m_cnt[j][47:32];
    end else begin
      j = int'(a) - 11;
      r[2:0] = m_sel[j]; r[11:8] = m_um[j]; r[18] = m_edge[j];
      r[20] = m_oven[j]; r[27:24] = m_thr[j];
    end
    return r;
  endfunction

  task automatic model_clk(input logic [31:0] ev, input logic fe, input logic [3:0] a,
                           input logic w, input logic [31:0] d);
    logic [2:0]  inc [5];
    logic        npnz [5];
    logic [4:0]  setb;
    logic [48:0] s;
    logic [3:0]  sub;
    int c;
    logic box, rc, rl, prst;
    inc[0] = {2'b0, fe};
    npnz[0] = 1'b0;
    for (int k = 1; k < 5; k++) begin
      sub = ev[m_sel[k]*4 +: 4];
      c = $countones(sub & m_um[k]);
      if (m_edge[k])           inc[k] = (c != 0 && !m_pnz[k]) ? 3'd1 : 3'd0;
      else if (m_thr[k] != 0)  inc[k] = (c >= int'(m_thr[k])) ? 3'd1 : 3'd0;
      else                     inc[k] = 3'(c);
      npnz[k] = (c != 0);
    end
    box = w && a == 0;
    rc  = box && d[1];
    rl  = box && d[0];
    setb = '0;
    for (int j = 0; j < 5; j++) begin
      prst = (j > 0) && w && (int'(a) == 11 + j) && d[17];
      if (rc || prst) m_cnt[j] = '0;
      else if (w && int'(a) == 2 + 2*j) m_cnt[j][31:0] = d;
      else if (w && int'(a) == 3 + 2*j) m_cnt[j][47:32] = d[15:0];
      else if (!m_frz) begin
        s = {1'b0, m_cnt[j]} + 49'(inc[j]);
        m_cnt[j] = s[47:0];
        if (s[48] && (j == 0 || m_oven[j])) setb[j] = 1'b1;
      end
    end
    m_stat = (m_stat & ~((w && a == 1) ? d[4:0] : 5'b0)) | setb;
    for (int k = 1; k < 5; k++) begin
      if (rl) begin
        m_sel[k] = '0; m_um[k] = '0; m_thr[k] = '0; m_edge[k] = 0; m_oven[k] = 0;
      end else if (w && int'(a) == 11 + k) begin
        m_sel[k] = d[2:0]; m_um[k] = d[11:8]; m_thr[k] = d[27:24];
        m_edge[k] = d[18]; m_oven[k] = d[20];
      end
      m_pnz[k] = npnz[k];
    end
    if (box) begin
      m_frz = d[8]; m_rsv = d[17:16];
    end
  endtask

  // mode 0: no check, 1: compare to model, 2: compare to literal
  task automatic cyc(input logic [31:0] ev, input logic fe, input logic [3:0] a, input logic w,
                     input logic [31:0] d, input int mode, input logic [31:0] lit, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    ev_i = ev; fixed_ev_i = fe; reg_addr_i = a; reg_wr_i = w; reg_wdata_i = d;
    #1;
    if (mode != 0) begin
      exp = (mode == 2) ? lit : model_read(a);
      n_chk++;
      if (reg_rdata_o !== exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata_o, exp);
      end
    end
    @(posedge clk);
    model_clk(ev, fe, a, w, d);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc('0, 1'b0, a, 1'b1, d, 0, '0, "");
  endtask

  task automatic rd_lit(input logic [3:0] a, input logic [31:0] v, input string tag);
    cyc('0, 1'b0, a, 1'b0, '0, 2, v, tag);
  endtask

  task automatic rd_mod(input logic [3:0] a, input string tag);
    cyc('0, 1'b0, a, 1'b0, '0, 1, '0, tag);
  endtask

  task automatic evc(input logic [31:0] ev, input logic fe);
    cyc(ev, fe, 4'd0, 1'b0, '0, 0, '0, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 5; i++) begin
      m_cnt[i] = '0; m_sel[i] = '0; m_um[i] = '0; m_thr[i] = '0;
      m_edge[i] = 0; m_oven[i] = 0; m_pnz[i] = 0;
    end
    m_stat = '0; m_frz = 0; m_rsv = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd_lit(4'(a), 32'h0, "R1");

    // R2 plain counting, lane select and unit mask
    wr(4'd12, 32'h0000_0F02);
    repeat (3) evc(mkev(2, 4'b1011) | mkev(1, 4'hF), 1'b1);
    rd_lit(4'd4, 32'd9, "R2");
    rd_lit(4'd2, 32'd3, "R2");
    wr(4'd12, 32'h0000_0302);
    repeat (2) evc(mkev(2, 4'hF) | mkev(3, 4'hF), 1'b0);
    rd_lit(4'd4, 32'd13, "R2");

    // R3 threshold
    wr(4'd13, 32'h0300_0F01);
    evc(mkev(1, 4'b0011), 1'b0);
    evc(mkev(1, 4'b0111), 1'b0);
    evc(mkev(1, 4'b1111), 1'b0);
    evc(mkev(1, 4'b0001), 1'b0);
    rd_lit(4'd6, 32'd2, "R3");

    // R4 edge detect, threshold field also set
    wr(4'd14, 32'h0104_0F00);
    evc(mkev(0, 4'b0001), 1'b0);
    evc(mkev(0, 4'b0011), 1'b0);
    evc('0, 1'b0);
    evc(mkev(0, 4'b0010), 1'b0);
    evc(mkev(0, 4'b0010), 1'b0);
    rd_lit(4'd8, 32'd2, "R4");

    // R11 write beats increment
    cyc(mkev(2, 4'hF), 1'b1, 4'd4, 1'b1, 32'h100, 0, '0, "");
    rd_lit(4'd4, 32'h100, "R11");
    cyc(mkev(2, 4'hF), 1'b0, 4'd5, 1'b1, 32'h0000_ABCD, 0, '0, "");
    rd_lit(4'd5, 32'h0000_ABCD, "R11");
    rd_lit(4'd4, 32'h100, "R11");
    wr(4'd5, 32'h0);

    // R5 freeze
    wr(4'd0, 32'h0000_0100);
    repeat (3) evc(32'hFFFF_FFFF, 1'b1);
    rd_lit(4'd4, 32'h100, "R5");
    rd_lit(4'd6, 32'd2, "R5");
    rd_mod(4'd2, "R5");
    rd_lit(4'd0, 32'h0000_0100, "R5");
    wr(4'd4, 32'h55);
    rd_lit(4'd4, 32'h55, "R5");
    wr(4'd0, 32'h0);
    evc(mkev(2, 4'h1), 1'b0);
    rd_lit(4'd4, 32'h56, "R5");

    // R6 clear all counters
    repeat (2) evc(32'hFFFF_FFFF, 1'b1);
    wr(4'd0, 32'h0000_0002);
    for (int a = 2; a < 12; a++) rd_lit(4'(a), 32'h0, "R6");
    rd_lit(4'd12, 32'h0000_0302, "R6");

    // R8 per-counter clear
    repeat (2) evc(32'hFFFF_FFFF, 1'b0);
    wr(4'd13, 32'h0002_0F01);
    rd_lit(4'd6, 32'h0, "R8");
    rd_lit(4'd4, 32'd4, "R8");
    rd_lit(4'd13, 32'h0000_0F01, "R8");

    // R9 overflow with and without enable, fixed counter
    wr(4'd12, 32'h0010_0F02);
    wr(4'd5, 32'h0000_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);
    evc(mkev(2, 4'b0001), 1'b0);
    rd_lit(4'd1, 32'h2, "R9");
    rd_lit(4'd4, 32'h0, "R9");
    rd_lit(4'd5, 32'h0, "R9");
    wr(4'd7, 32'h0000_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    evc(mkev(1, 4'b0001), 1'b0);
    rd_lit(4'd6, 32'h0, "R9");
    rd_lit(4'd1, 32'h2, "R9");
    wr(4'd3, 32'h0000_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    evc('0, 1'b1);
    rd_lit(4'd1, 32'h3, "R9");

    // R10 write-one-to-clear
    wr(4'd1, 32'h0);
    rd_lit(4'd1, 32'h3, "R10");
    wr(4'd1, 32'h2);
    rd_lit(4'd1, 32'h1, "R10");
    wr(4'd3, 32'h0000_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 4'd1, 1'b1, 32'h1, 0, '0, "");
    rd_lit(4'd1, 32'h1, "R10");
    wr(4'd1, 32'h1);
    rd_lit(4'd1, 32'h0, "R10");

    // R12 reserved and ignored bits
    wr(4'd0, 32'hFFFF_FEFC);
    rd_lit(4'd0, 32'h0003_0000, "R12");
    wr(4'd1, 32'hFFFF_FFE0);
    rd_lit(4'd1, 32'h0, "R12");
    repeat (2) evc(32'hFFFF_FFFF, 1'b1);
    rd_mod(4'd4, "R12");

    // R7 clear control registers
    wr(4'd0, 32'h0003_0001);
    for (int a = 12; a < 16; a++) rd_lit(4'(a), 32'h0, "R7");
    rd_lit(4'd0, 32'h0003_0000, "R7");

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r, ev, d;
      logic [3:0]  a;
      logic        w, fe;
      r  = $urandom % 32;
      ev = $urandom;
      fe = 1'($urandom);
      w  = 1'b1;
      a  = '0;
      d  = '0;
      case (r)
        0, 1: begin
          a = 4'(12 + $urandom % 4);
          d = $urandom & 32'h0F17_0F07;
          if ($urandom % 8 != 0) d[17] = 1'b0;
        end
        2: begin a = 4'(3 + 2 * ($urandom % 5)); d = 32'h0000_FFFF; end
        3: begin a = 4'(2 + 2 * ($urandom % 5)); d = 32'hFFFF_FFF0 | ($urandom % 16); end
        4: begin a = 4'd1; d = $urandom; end
        5: begin
          a = 4'd0;
          d = $urandom & 32'h0003_0100;
          if ($urandom % 16 == 0) d[1:0] = 2'($urandom);
        end
        default: begin w = 1'b0; a = 4'($urandom % 16); end
      endcase
      cyc(ev, fe, a, w, d, w ? 0 : 1, '0, "RND");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule